// File: doc/BRIEF.md
# Hub Strap Sampler and Configuration Decoder

This block reads the board-level strap pins of a multi-host USB hub at the moment the active-low reset is released. It turns them into the settings the rest of the hub runs with: where the configuration comes from, how downstream ports get assigned to hosts, how the indicator LEDs behave, which downstream ports are switched off for good, which carry permanently attached devices, and the polarity of the port-power switches. The serial memory reader and the bus slave register engine consume these settings but are not part of this block.

The block also owns the downstream port-power pins. While reset is held, every power pin sits at its off level, and that level comes straight from the polarity strap through gates, not through a flop, so no power switch turns on during reset. After release the polarity is frozen. The hub's requested power enables then drive the pins, and a disabled port is always kept off.

The captured straps settle into output registers on the first rising clock edge after release. From then on `cfg_valid` is high, and the fields keep their values until the next reset.

Top module: `hub_strap_cfg`

## Requirements
- R1: The select, disable, non-removable and polarity straps are taken at the last rising clock edge while `rst_n` is low. All decoded fields and `cfg_valid`=1 appear at the first rising edge with `rst_n` high. Later strap changes have no effect until the next reset.
- R2: While `rst_n` is low, `cfg_valid` and every decoded field (source, modes, flags, address, masks, LED polarity) are 0.
- R3: Encodings: `cfg_src` 0=internal, 1=bus slave, 2=serial memory; `assign_mode` 0=embedded, 1=level peripheral, 2=edge peripheral; `led_mode` 0=USB, 1=host ownership, 2=host ownership with speed. By select code {src,assign,led,straps_en,unassigned_ok}: 000→{0,0,0,1,0}, 001→{1,0,0,0,1}, 010→{0,1,0,1,0}, 011→{2,0,0,0,1}, 100→{0,2,1,1,1}, 101→{0,2,2,0,1}.
- R4: `slave_addr` is 7'h2C (binary 0101100) for select code 001 and 0 for every other code.
- R5: Select codes 110 and 111 decode exactly as 000 and set `sel_err`=1. All valid codes give `sel_err`=0.
- R6: `port_dis` bit i is port i+1. When straps are enabled, disable strap values 0,1,2,3 give 4'b0000, 4'b1000, 4'b1100 and 4'b1110. When straps are disabled the mask is 0.
- R7: `port_nrem` bit i is port i+1. When straps are enabled, non-removable strap values 0,1,2,3 give 4'b0000, 4'b0001, 4'b0011 and 4'b0111. When straps are disabled the mask is 0.
- R8: When straps are enabled, `led_act_low` = {dis[1], dis[0], nrem[1], nrem[0]} (bit 3 is port 4). When straps are disabled it is 4'b1111.
- R9: While `rst_n` is low, every `pwr_pin` equals the inverse of `pol_pin` and follows it with no clock edge.
- R10: After release, `pwr_active_high` equals the captured polarity. `pwr_pin[i]` equals that polarity only when `cfg_valid`, `pwr_on[i]` and not `port_dis[i]` all hold; otherwise it equals the inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release captures the straps |
| sel_pin | input | 3 | Configuration select strap |
| dis_pin | input | 2 | Port disable count strap |
| nrem_pin | input | 2 | Non-removable count strap |
| pol_pin | input | 1 | Port power polarity strap, 1 = active high |
| pwr_on | input | 4 | Requested power enable per port, from hub logic |
| cfg_valid | output | 1 | Decoded fields are valid |
| cfg_src | output | 2 | Configuration source |
| assign_mode | output | 2 | Port assignment mode |
| led_mode | output | 2 | LED indication mode |
| led_straps_en | output | 1 | Strap pins act as disable/non-removable straps |
| unassigned_ok | output | 1 | Ports may be left without a host |
| sel_err | output | 1 | Reserved select code was captured |
| slave_addr | output | 7 | Bus slave address, 0 when not in bus slave mode |
| port_dis | output | 4 | Disabled port mask |
| port_nrem | output | 4 | Non-removable port mask |
| led_act_low | output | 4 | Per-port LED active-low flag |
| pwr_active_high | output | 1 | Captured power polarity |
| pwr_pin | output | 4 | Port power switch pins |

## Verification
The bench goes after the polarity path during reset. It toggles the polarity strap with no clock running, so a design that registered the off level would let a power switch sit on through reset. It walks all eight select codes, including both reserved ones. A decoder with a missing fallback would leave X or stray modes and a silent error flag, and one that ignored the strap-disable column would report disabled ports in codes 001, 011 and 101. It flips every strap after release and requests power on ports that are disabled. A design that kept sampling after reset would drift, and one that left disabled ports out of the power gating would power a port that is meant to be dead.

// File: rtl/hub_strap_cfg_pkg.sv
package hub_strap_cfg_pkg;

  typedef enum logic [1:0] {
    SRC_INTERNAL   = 2'd0,
    SRC_BUS_SLAVE  = 2'd1,
    SRC_SERIAL_MEM = 2'd2
  } cfg_src_e;

  typedef enum logic [1:0] {
    ASSIGN_EMBEDDED = 2'd0,
    ASSIGN_LEVEL    = 2'd1,
    ASSIGN_EDGE     = 2'd2
  } assign_mode_e;

  typedef enum logic [1:0] {
    LED_USB        = 2'd0,
    LED_HOST       = 2'd1,
    LED_HOST_SPEED = 2'd2
  } led_mode_e;

  typedef struct packed {
    cfg_src_e     src;
    assign_mode_e amode;
    led_mode_e    lmode;
    logic         straps_en;
    logic         unassigned_ok;
    logic         sel_err;
  } mode_t;

  // Select code to operating mode; reserved codes fall back to code 000.
  function automatic mode_t decode_mode(input logic [2:0] sel);
    mode_t m;
    m = '{src: SRC_INTERNAL, amode: ASSIGN_EMBEDDED, lmode: LED_USB,
          straps_en: 1'b1, unassigned_ok: 1'b0, sel_err: 1'b0};
    case (sel)
      3'b000: ;
      3'b001: begin
        m.src = SRC_BUS_SLAVE; m.straps_en = 1'b0; m.unassigned_ok = 1'b1;
      end
      3'b010: m.amode = ASSIGN_LEVEL;
      3'b011: begin
        m.src = SRC_SERIAL_MEM; m.straps_en = 1'b0; m.unassigned_ok = 1'b1;
      end
      3'b100: begin
        m.amode = ASSIGN_EDGE; m.lmode = LED_HOST; m.unassigned_ok = 1'b1;
      end
      3'b101: begin
        m.amode = ASSIGN_EDGE; m.lmode = LED_HOST_SPEED;
        m.straps_en = 1'b0; m.unassigned_ok = 1'b1;
      end
      default: m.sel_err = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hub_strap_capture.sv
module hub_strap_capture #(
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         sel_pin,
  input  logic [STRAP_W-1:0] dis_pin,
  input  logic [STRAP_W-1:0] nrem_pin,
  input  logic               pol_pin,
  output logic [2:0]         sel_q,
  output logic [STRAP_W-1:0] dis_q,
  output logic [STRAP_W-1:0] nrem_q,
  output logic               pol_q
);
  // Track the pins while reset is held; freeze at release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= sel_pin;
      dis_q  <= dis_pin;
      nrem_q <= nrem_pin;
      pol_q  <= pol_pin;
    end
  end
endmodule

// File: rtl/hub_cfg_decode.sv
module hub_cfg_decode
  import hub_strap_cfg_pkg::*;
#(
  parameter int         NPORTS     = 4,
  parameter int         STRAP_W    = 2,
  parameter logic [6:0] SLAVE_ADDR = 7'h2C
) (
  input  logic [2:0]         sel_q,
  input  logic [STRAP_W-1:0] dis_q,
  input  logic [STRAP_W-1:0] nrem_q,
  output mode_t              mode,
  output logic [6:0]         addr,
  output logic [NPORTS-1:0]  dis_mask,
  output logic [NPORTS-1:0]  nrem_mask,
  output logic [NPORTS-1:0]  led_low
);
  localparam int LED_HI_BASE = NPORTS - STRAP_W;

  // Count of ports taken from the top end.
  function automatic logic [NPORTS-1:0] top_mask(input logic [STRAP_W-1:0] cnt);
    logic [NPORTS-1:0] m;
    for (int i = 0; i < NPORTS; i++) m[i] = (i >= NPORTS - int'(cnt));
    return m;
  endfunction

  // Count of ports taken from the bottom end.
  function automatic logic [NPORTS-1:0] low_mask(input logic [STRAP_W-1:0] cnt);
    logic [NPORTS-1:0] m;
    for (int i = 0; i < NPORTS; i++) m[i] = (i < int'(cnt));
    return m;
  endfunction

  logic [NPORTS-1:0] strap_led;

  assign mode      = decode_mode(sel_q);
  assign addr      = (sel_q == 3'b001) ? SLAVE_ADDR : 7'd0;
  assign dis_mask  = mode.straps_en ? top_mask(dis_q)  : '0;
  assign nrem_mask = mode.straps_en ? low_mask(nrem_q) : '0;
  assign led_low   = mode.straps_en ? strap_led : '1;

  for (genvar i = 0; i < NPORTS; i++) begin : g_led
    if (i >= LED_HI_BASE) begin : g_hi
      assign strap_led[i] = dis_q[i-LED_HI_BASE];
    end else if (i < STRAP_W) begin : g_lo
      assign strap_led[i] = nrem_q[i];
    end else begin : g_mid
      assign strap_led[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hub_pwr_drive.sv
module hub_pwr_drive #(
  parameter int NPORTS = 4
) (
  input  logic              rst_n,
  input  logic              pol_pin,
  input  logic              pol_q,
  input  logic              cfg_valid,
  input  logic [NPORTS-1:0] pwr_on,
  input  logic [NPORTS-1:0] port_dis,
  output logic [NPORTS-1:0] pwr_pin
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_pin
    logic grant;
    assign grant      = cfg_valid & pwr_on[i] & ~port_dis[i];
    // During reset the off level comes straight from the strap pin.
    assign pwr_pin[i] = !rst_n ? ~pol_pin : (grant ? pol_q : ~pol_q);
  end
endmodule

// File: rtl/hub_strap_cfg.sv
module hub_strap_cfg
  import hub_strap_cfg_pkg::*;
#(
  parameter int         NPORTS     = 4,
  parameter int         STRAP_W    = 2,
  parameter logic [6:0] SLAVE_ADDR = 7'h2C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         sel_pin,
  input  logic [STRAP_W-1:0] dis_pin,
  input  logic [STRAP_W-1:0] nrem_pin,
  input  logic               pol_pin,
  input  logic [NPORTS-1:0]  pwr_on,
  output logic               cfg_valid,
  output logic [1:0]         cfg_src,
  output logic [1:0]         assign_mode,
  output logic [1:0]         led_mode,
  output logic               led_straps_en,
  output logic               unassigned_ok,
  output logic               sel_err,
  output logic [6:0]         slave_addr,
  output logic [NPORTS-1:0]  port_dis,
  output logic [NPORTS-1:0]  port_nrem,
  output logic [NPORTS-1:0]  led_act_low,
  output logic               pwr_active_high,
  output logic [NPORTS-1:0]  pwr_pin
);
  logic [2:0]         sel_q;
  logic [STRAP_W-1:0] dis_q, nrem_q;
  logic               pol_q;
  mode_t              mode_d;
  logic [6:0]         addr_d;
  logic [NPORTS-1:0]  dis_d, nrem_d, led_d;
  logic               load_cfg;   // first edge after release

  hub_strap_capture #(.STRAP_W(STRAP_W)) i_capture (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .dis_pin(dis_pin),
    .nrem_pin(nrem_pin), .pol_pin(pol_pin), .sel_q(sel_q), .dis_q(dis_q),
    .nrem_q(nrem_q), .pol_q(pol_q)
  );

  hub_cfg_decode #(.NPORTS(NPORTS), .STRAP_W(STRAP_W), .SLAVE_ADDR(SLAVE_ADDR)) i_decode (
    .sel_q(sel_q), .dis_q(dis_q), .nrem_q(nrem_q), .mode(mode_d),
    .addr(addr_d), .dis_mask(dis_d), .nrem_mask(nrem_d), .led_low(led_d)
  );

  assign load_cfg = !cfg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid     <= 1'b0;
      cfg_src       <= '0;
      assign_mode   <= '0;
      led_mode      <= '0;
      led_straps_en <= 1'b0;
      unassigned_ok <= 1'b0;
      sel_err       <= 1'b0;
      slave_addr    <= '0;
      port_dis      <= '0;
      port_nrem     <= '0;
      led_act_low   <= '0;
    end else if (load_cfg) begin
      cfg_valid     <= 1'b1;
      cfg_src       <= mode_d.src;
      assign_mode   <= mode_d.amode;
      led_mode      <= mode_d.lmode;
      led_straps_en <= mode_d.straps_en;
      unassigned_ok <= mode_d.unassigned_ok;
      sel_err       <= mode_d.sel_err;
      slave_addr    <= addr_d;
      port_dis      <= dis_d;
      port_nrem     <= nrem_d;
      led_act_low   <= led_d;
    end
  end

  assign pwr_active_high = pol_q;

  hub_pwr_drive #(.NPORTS(NPORTS)) i_pwr (
    .rst_n(rst_n), .pol_pin(pol_pin), .pol_q(pol_q), .cfg_valid(cfg_valid),
    .pwr_on(pwr_on), .port_dis(port_dis), .pwr_pin(pwr_pin)
  );
endmodule

// File: rtl/hub_strap_cfg_chk.sv
module hub_strap_cfg_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pol_pin,
  input logic              pol_q,
  input logic              cfg_valid,
  input logic [1:0]        cfg_src,
  input logic [1:0]        assign_mode,
  input logic [1:0]        led_mode,
  input logic              sel_err,
  input logic [NPORTS-1:0] port_dis,
  input logic [NPORTS-1:0] pwr_pin
);
  // R9
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_pwr_off_chk: assert (pwr_pin == {NPORTS{~pol_pin}});
    end
  end

  // R1
  valid_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> cfg_valid);

  // R1
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> $stable({cfg_src, assign_mode, led_mode, sel_err, port_dis}));

  // R5
  fallback_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (cfg_src == 2'd0 && assign_mode == 2'd0 && led_mode == 2'd0));

  // R10
  disabled_port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ((pwr_pin ^ {NPORTS{~pol_q}}) & port_dis) == '0);

  // R10
  polarity_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> $stable(pol_q));
endmodule

bind hub_strap_cfg hub_strap_cfg_chk #(.NPORTS(NPORTS)) i_chk (
  .clk(clk), .rst_n(rst_n), .pol_pin(pol_pin), .pol_q(pol_q),
  .cfg_valid(cfg_valid), .cfg_src(cfg_src), .assign_mode(assign_mode),
  .led_mode(led_mode), .sel_err(sel_err), .port_dis(port_dis), .pwr_pin(pwr_pin)
);

// File: tb/test_hub_strap_cfg.sv
module test_hub_strap_cfg;
  localparam int NP = 4;

  typedef struct packed {
    logic [2:0] sel;
    logic [1:0] dis;
    logic [1:0] nrem;
    logic       pol;
    logic [3:0] on;
    logic [1:0] e_src;
    logic [1:0] e_amode;
    logic [1:0] e_lmode;
    logic       e_straps;
    logic       e_ua;
    logic       e_err;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'b000, 2'd1, 2'd2, 1'b1, 4'b1111, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    '{3'b001, 2'd3, 2'd3, 1'b0, 4'b0101, 2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    '{3'b010, 2'd2, 2'd1, 1'b0, 4'b1110, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0},
    '{3'b011, 2'd2, 2'd2, 1'b1, 4'b1010, 2'd2, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    '{3'b100, 2'd3, 2'd0, 1'b1, 4'b1111, 2'd0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0},
    '{3'b101, 2'd1, 2'd3, 1'b1, 4'b0011, 2'd0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0},
    '{3'b110, 2'd0, 2'd3, 1'b0, 4'b1001, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1},
    '{3'b111, 2'd3, 2'd1, 1'b1, 4'b1111, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel_pin = '0;
  logic [1:0] dis_pin = '0, nrem_pin = '0;
  logic pol_pin = 1'b1;
  logic [NP-1:0] pwr_on = '0;
  logic cfg_valid, led_straps_en, unassigned_ok, sel_err, pwr_active_high;
  logic [1:0] cfg_src, assign_mode, led_mode;
  logic [6:0] slave_addr;
  logic [NP-1:0] port_dis, port_nrem, led_act_low, pwr_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hub_strap_cfg i_hub_strap_cfg (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .dis_pin(dis_pin),
    .nrem_pin(nrem_pin), .pol_pin(pol_pin), .pwr_on(pwr_on),
    .cfg_valid(cfg_valid), .cfg_src(cfg_src), .assign_mode(assign_mode),
    .led_mode(led_mode), .led_straps_en(led_straps_en),
    .unassigned_ok(unassigned_ok), .sel_err(sel_err), .slave_addr(slave_addr),
    .port_dis(port_dis), .port_nrem(port_nrem), .led_act_low(led_act_low),
    .pwr_active_high(pwr_active_high), .pwr_pin(pwr_pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dis(input logic [1:0] d, input logic en);
    if (!en) return 4'b0000;
    case (d)
      2'd0: return 4'b0000;
      2'd1: return 4'b1000;
      2'd2: return 4'b1100;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] exp_nrem(input logic [1:0] n, input logic en);
    if (!en) return 4'b0000;
    case (n)
      2'd0: return 4'b0000;
      2'd1: return 4'b0001;
      2'd2: return 4'b0011;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic logic [3:0] exp_pwr(input logic [3:0] on, input logic [3:0] dis, input logic pol);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (on[i] && !dis[i]) ? pol : !pol;
    return r;
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    rst_n = 1'b0; sel_pin = v.sel; dis_pin = v.dis; nrem_pin = v.nrem;
    pol_pin = v.pol; pwr_on = v.on;
    #1;
    check("R9 off level in reset", pwr_pin, {NP{~v.pol}});
    check("R2 valid low in reset", cfg_valid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 valid waits for edge", cfg_valid, 0);
    @(negedge clk);
    check("R1 valid after release", cfg_valid, 1);
    check("R3 mode fields", {cfg_src, assign_mode, led_mode, led_straps_en, unassigned_ok},
          {v.e_src, v.e_amode, v.e_lmode, v.e_straps, v.e_ua});
    check("R4 slave address", slave_addr, (v.sel == 3'b001) ? 7'h2C : 7'h00);
    check("R5 select error", sel_err, v.e_err);
    check("R6 disable mask", port_dis, exp_dis(v.dis, v.e_straps));
    check("R7 non-removable mask", port_nrem, exp_nrem(v.nrem, v.e_straps));
    check("R8 LED polarity", led_act_low,
          v.e_straps ? {v.dis[1], v.dis[0], v.nrem[1], v.nrem[0]} : 4'b1111);
    check("R10 polarity out", pwr_active_high, v.pol);
    check("R10 power pins", pwr_pin, exp_pwr(v.on, exp_dis(v.dis, v.e_straps), v.pol));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] snap;
    #1;
    check("R2 reset state fields",
          {cfg_src, assign_mode, led_mode, led_straps_en, unassigned_ok, sel_err},
          '0);
    check("R2 reset masks", {slave_addr, port_dis, port_nrem, led_act_low}, '0);

    for (int k = 0; k < 8; k++) apply(VEC[k]);

    // R1: strap changes after release are ignored
    apply(VEC[2]);
    snap = {cfg_src, assign_mode, led_mode, sel_err};
    @(negedge clk);
    sel_pin = 3'b101; dis_pin = 2'd0; nrem_pin = 2'd3; pol_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 fields ignore strap change", {cfg_src, assign_mode, led_mode, sel_err}, snap);
    check("R1 masks ignore strap change", {port_dis, port_nrem, led_act_low}, 12'b1100_0001_1001);
    check("R10 polarity ignores pin", pwr_active_high, 0);

    // R10: request power on every port, disabled ports stay off (active low)
    pwr_on = 4'b1111;
    #1;
    check("R10 disabled ports off", pwr_pin, 4'b1100);
    pwr_on = 4'b0000;
    #1;
    check("R10 all off", pwr_pin, 4'b1111);

    // R9: polarity strap followed without clock during reset
    @(negedge clk);
    rst_n = 1'b0; pwr_on = 4'b1111;
    #1;
    pol_pin = 1'b0;
    #1;
    check("R9 follows pin low", pwr_pin, 4'b1111);
    pol_pin = 1'b1;
    #1;
    check("R9 follows pin high", pwr_pin, 4'b0000);
    check("R2 fields cleared in reset", {cfg_valid, port_dis, led_act_low}, '0);

    // R6 R7: full counts with straps enabled, active high power
    @(negedge clk);
    sel_pin = 3'b000; dis_pin = 2'd3; nrem_pin = 2'd3; pol_pin = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 max disable", port_dis, 4'b1110);
    check("R7 max non-removable", port_nrem, 4'b0111);
    check("R10 only port 1 powered", pwr_pin, 4'b0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule